// File: doc/BRIEF.md
# Timer Compare Unit with Force

This block is a 16-bit up-counter with two output compare channels, A and B. The counter advances only on cycles where the timer-clock enable is high, and each such enabled tick is one timer clock. On every tick, each channel compares its own compare register with the counter value. On a match, the channel sets its sticky interrupt flag and applies its selected action to its waveform output. When clear-on-compare mode is on, channel A's compare value acts as the top of the count, and the counter returns to zero after reaching it.

Software can load the counter and either compare register directly. Loading the counter suppresses compare matches, on every channel, for the first timer tick after the load. Each channel also has a force strobe. The strobe applies that channel's waveform action at once. It never sets a flag and never restarts the counter. A control readback port returns the action fields, with the force positions always reading zero.

Top module: `tcmp_top`

## Requirements
- R1: After synchronous reset, the counter, both waveform outputs and both interrupt flags are 0, and both compare registers hold 0. A tick at count 0 therefore matches both channels.
- R2: On a tick with no counter write, the counter steps by one and wraps from 0xFFFF to 0x0000 when clear-on-compare mode is off. Without a tick or a write, the counter holds its value.
- R3: A counter write loads `cnt_wr_data` at the next clock edge. It takes priority over a tick in the same cycle, so that tick neither counts nor compares.
- R4: When a tick evaluates with count equal to a channel's compare value, that channel's flag is 1 from the next edge. The flag stays set until a cycle with its `flag_clr` bit at 1. If a set and a clear arrive on the same edge, the set wins.
- R5: The 2-bit action code for a channel sits in `act_sel[2*i+1:2*i]`, with channel A as index 0. The codes are: 0 leaves the output unchanged, 1 toggles it, 2 drives it to 0, and 3 drives it to 1. The action applies on a match or on a force.
- R6: With `ctc_mode` at 1, a match on channel A makes the counter go to 0 at that edge instead of stepping. A match on channel B never clears the counter.
- R7: A force strobe on a channel applies its action at the next edge whether or not a tick is present. A force and a match on the same edge act only once.
- R8: A force strobe never sets an interrupt flag. It never clears or changes the counter, even in clear-on-compare mode.
- R9: After a counter write, the first later tick, however many cycles later it comes, performs no compare on any channel. The counter still steps on that tick. Every following tick compares normally.
- R10: `ctrl_rd[3*i+1:3*i]` echoes channel i's action code, and `ctrl_rd[3*i+2]` (the force position) always reads 0, even while the force strobe is high.
- R11: A compare register write loads `cmp_wr_data` at the next edge, and that value is used by the next tick.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Timer-clock enable |
| ctc_mode | input | 1 | 1 = clear counter on channel A match |
| cnt_wr_en | input | 1 | Counter load strobe |
| cnt_wr_data | input | 16 | Counter load value |
| cmp_wr_en | input | 2 | Per-channel compare register load strobe |
| cmp_wr_data | input | 16 | Compare register load value |
| act_sel | input | 4 | Per-channel 2-bit waveform action |
| force_stb | input | 2 | Per-channel force-compare strobe |
| flag_clr | input | 2 | Write-one-to-clear for the flags |
| count | output | 16 | Counter value |
| wave_out | output | 2 | Per-channel waveform output |
| irq_flag | output | 2 | Per-channel sticky interrupt flag |
| ctrl_rd | output | 6 | Control readback: action fields, force bits read 0 |

## Verification
Every registered result in this block (count, flags, waveform outputs) is due one clock edge after the cycle that causes it. A match is judged on the count held before that edge. The bench changes its inputs just after a rising edge and queues the expected values for the edge it has just applied. The monitor compares them at the following falling edge, so each item reflects exactly one edge. `ctrl_rd` is combinational from `act_sel`. It is compared at that same falling edge, and it is also checked directly while a force strobe is held high.

// File: rtl/tcmp_pkg.sv
package tcmp_pkg;

    localparam int ACT_W = 2;

    typedef enum logic [ACT_W-1:0] {
        ACT_HOLD   = 2'd0,
        ACT_TOGGLE = 2'd1,
        ACT_LOW    = 2'd2,
        ACT_HIGH   = 2'd3
    } wave_act_e;

    typedef struct packed {
        logic match;
        logic wave;
        logic flag;
    } chan_state_t;

    function automatic logic next_wave(input logic cur, input wave_act_e act, input logic fire);
        logic nxt;
        nxt = cur;
        if (fire) begin
            case (act)
                ACT_TOGGLE: nxt = ~cur;
                ACT_LOW:    nxt = 1'b0;
                ACT_HIGH:   nxt = 1'b1;
                default:    nxt = cur;
            endcase
        end
        return nxt;
    endfunction

endpackage

// File: rtl/tcmp_counter.sv
module tcmp_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             wr_en,
    input  logic [CNT_W-1:0] wr_data,
    input  logic             clr_top,
    output logic [CNT_W-1:0] count,
    output logic             eval
);
    logic [CNT_W-1:0] cnt_q;
    logic             blk_pend_q;

    // A tick compares only if it is not displaced by a write and not blocked.
    assign eval  = tick && !wr_en && !blk_pend_q;
    assign count = cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q      <= '0;
            blk_pend_q <= 1'b0;
        end else if (wr_en) begin
            cnt_q      <= wr_data;
            blk_pend_q <= 1'b1;
        end else if (tick) begin
            blk_pend_q <= 1'b0;
            if (clr_top) cnt_q <= '0;
            else         cnt_q <= cnt_q + CNT_W'(1);
        end
    end
endmodule

// File: rtl/tcmp_channel.sv
module tcmp_channel
    import tcmp_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             eval,
    input  logic [CNT_W-1:0] count,
    input  logic             cmp_wr_en,
    input  logic [CNT_W-1:0] cmp_wr_data,
    input  logic [ACT_W-1:0] act,
    input  logic             force_stb,
    input  logic             flag_clr,
    output chan_state_t      st
);
    logic [CNT_W-1:0] cmp_q;
    logic             wave_q;
    logic             flag_q;
    logic             hit;

    assign hit      = eval && (count == cmp_q);
    assign st.match = hit;
    assign st.wave  = wave_q;
    assign st.flag  = flag_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cmp_q  <= '0;
            wave_q <= 1'b0;
            flag_q <= 1'b0;
        end else begin
            if (cmp_wr_en) cmp_q <= cmp_wr_data;
            wave_q <= next_wave(wave_q, wave_act_e'(act), hit || force_stb);
            if (hit)           flag_q <= 1'b1;
            else if (flag_clr) flag_q <= 1'b0;
        end
    end
endmodule

// File: rtl/tcmp_top.sv
module tcmp_top
    import tcmp_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int NUM_CH = 2
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    tick,
    input  logic                    ctc_mode,
    input  logic                    cnt_wr_en,
    input  logic [CNT_W-1:0]        cnt_wr_data,
    input  logic [NUM_CH-1:0]       cmp_wr_en,
    input  logic [CNT_W-1:0]        cmp_wr_data,
    input  logic [NUM_CH*ACT_W-1:0] act_sel,
    input  logic [NUM_CH-1:0]       force_stb,
    input  logic [NUM_CH-1:0]       flag_clr,
    output logic [CNT_W-1:0]        count,
    output logic [NUM_CH-1:0]       wave_out,
    output logic [NUM_CH-1:0]       irq_flag,
    output logic [NUM_CH*(ACT_W+1)-1:0] ctrl_rd
);
    localparam int RD_W = ACT_W + 1;

    logic        eval;
    logic        clr_top;
    chan_state_t ch_st [NUM_CH];

    // Channel 0 is the one whose compare value serves as top.
    assign clr_top = ctc_mode && ch_st[0].match;

    tcmp_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk     (clk),
        .rst     (rst),
        .tick    (tick),
        .wr_en   (cnt_wr_en),
        .wr_data (cnt_wr_data),
        .clr_top (clr_top),
        .count   (count),
        .eval    (eval)
    );

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        tcmp_channel #(.CNT_W(CNT_W)) u_ch (
            .clk         (clk),
            .rst         (rst),
            .eval        (eval),
            .count       (count),
            .cmp_wr_en   (cmp_wr_en[i]),
            .cmp_wr_data (cmp_wr_data),
            .act         (act_sel[i*ACT_W +: ACT_W]),
            .force_stb   (force_stb[i]),
            .flag_clr    (flag_clr[i]),
            .st          (ch_st[i])
        );
        assign wave_out[i] = ch_st[i].wave;
        assign irq_flag[i] = ch_st[i].flag;
        // Force position is a strobe and never holds state.
        assign ctrl_rd[i*RD_W +: RD_W] = {1'b0, act_sel[i*ACT_W +: ACT_W]};
    end
endmodule

// File: rtl/tcmp_checker.sv
module tcmp_checker #(
    parameter int CNT_W  = 16,
    parameter int NUM_CH = 2
) (
    input logic              clk,
    input logic              rst,
    input logic              tick,
    input logic              ctc_mode,
    input logic              cnt_wr_en,
    input logic [CNT_W-1:0]  cnt_wr_data,
    input logic [NUM_CH-1:0] force_stb,
    input logic [NUM_CH-1:0] flag_clr,
    input logic [CNT_W-1:0]  count,
    input logic [NUM_CH-1:0] irq_flag
);
    assert_count_hold_R2: assert property (@(posedge clk) disable iff (rst)
        (!tick && !cnt_wr_en) |=> $stable(count));

    assert_count_step_R2: assert property (@(posedge clk) disable iff (rst)
        (tick && !cnt_wr_en && !ctc_mode) |=> (count == $past(count) + CNT_W'(1)));

    assert_wr_load_R3: assert property (@(posedge clk) disable iff (rst)
        cnt_wr_en |=> (count == $past(cnt_wr_data)));

    assert_blocked_tick_R9: assert property (@(posedge clk) disable iff (rst)
        (tick && !cnt_wr_en && $past(cnt_wr_en)) |=> ((irq_flag & ~$past(irq_flag)) == '0));

    for (genvar i = 0; i < NUM_CH; i++) begin : g_chk
        assert_flag_cause_R4: assert property (@(posedge clk) disable iff (rst)
            $rose(irq_flag[i]) |-> $past(tick && !cnt_wr_en));

        assert_force_no_flag_R8: assert property (@(posedge clk) disable iff (rst)
            (force_stb[i] && !tick && !irq_flag[i]) |=> !irq_flag[i]);

        assert_clear_sticks_R4: assert property (@(posedge clk) disable iff (rst)
            (irq_flag[i] && !flag_clr[i]) |=> irq_flag[i]);
    end
endmodule

bind tcmp_top tcmp_checker #(.CNT_W(CNT_W), .NUM_CH(NUM_CH)) u_tcmp_chk (
    .clk         (clk),
    .rst         (rst),
    .tick        (tick),
    .ctc_mode    (ctc_mode),
    .cnt_wr_en   (cnt_wr_en),
    .cnt_wr_data (cnt_wr_data),
    .force_stb   (force_stb),
    .flag_clr    (flag_clr),
    .count       (count),
    .irq_flag    (irq_flag)
);

// File: tb/tcmp_top_test.sv
module tcmp_top_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick = 1'b0;
    logic        ctc_mode = 1'b0;
    logic        cnt_wr_en = 1'b0;
    logic [15:0] cnt_wr_data = '0;
    logic [1:0]  cmp_wr_en = '0;
    logic [15:0] cmp_wr_data = '0;
    logic [3:0]  act_sel = '0;
    logic [1:0]  force_stb = '0;
    logic [1:0]  flag_clr = '0;
    logic [15:0] count;
    logic [1:0]  wave_out;
    logic [1:0]  irq_flag;
    logic [5:0]  ctrl_rd;

    int vectors = 0;
    int misses  = 0;
    bit done    = 1'b0;

    string       q_tag  [$];
    logic [15:0] q_cnt  [$];
    logic [1:0]  q_wave [$];
    logic [1:0]  q_flag [$];

    always #2.5 clk = ~clk;

    tcmp_top uut (
        .clk(clk), .rst(rst), .tick(tick), .ctc_mode(ctc_mode),
        .cnt_wr_en(cnt_wr_en), .cnt_wr_data(cnt_wr_data),
        .cmp_wr_en(cmp_wr_en), .cmp_wr_data(cmp_wr_data),
        .act_sel(act_sel), .force_stb(force_stb), .flag_clr(flag_clr),
        .count(count), .wave_out(wave_out), .irq_flag(irq_flag), .ctrl_rd(ctrl_rd)
    );

    function automatic logic [5:0] exp_ctrl(input logic [3:0] a);
        return {1'b0, a[3:2], 1'b0, a[1:0]};
    endfunction

    // Advance one edge, then drop all single-cycle strobes.
    task automatic step();
        @(posedge clk);
        #1;
        tick = 0; cnt_wr_en = 0; cmp_wr_en = '0; force_stb = '0; flag_clr = '0;
    endtask

    task automatic expect_out(input string tag, input logic [15:0] c,
                              input logic [1:0] w, input logic [1:0] f);
        q_tag.push_back(tag); q_cnt.push_back(c);
        q_wave.push_back(w);  q_flag.push_back(f);
    endtask

    // Monitor: compare queued expectations half a period after the edge.
    always @(negedge clk) begin
        while (q_tag.size() > 0) begin
            string t; logic [15:0] c; logic [1:0] w; logic [1:0] f;
            t = q_tag.pop_front(); c = q_cnt.pop_front();
            w = q_wave.pop_front(); f = q_flag.pop_front();
            vectors++;
            if (count !== c || wave_out !== w || irq_flag !== f || ctrl_rd !== exp_ctrl(act_sel)) begin
                misses++;
                $display("FAIL %s: actual cnt=%h wave=%b flag=%b ctrl=%b expected cnt=%h wave=%b flag=%b ctrl=%b",
                         t, count, wave_out, irq_flag, ctrl_rd, c, w, f, exp_ctrl(act_sel));
            end
        end
    end

    task automatic tick_n(input int n);
        for (int k = 0; k < n; k++) begin
            tick = 1; step();
        end
    endtask

    initial begin
        repeat (3) step();
        rst = 0; step();
        expect_out("R1 reset state", 16'h0000, 2'b00, 2'b00);

        act_sel = 4'b1101;                  // A toggle, B set
        tick = 1; step();
        expect_out("R1 compare regs zero match at count 0", 16'h0001, 2'b11, 2'b11);

        flag_clr = 2'b11; step();
        expect_out("R4 write-one clears flags", 16'h0001, 2'b11, 2'b00);

        cmp_wr_en = 2'b01; cmp_wr_data = 16'd5; step();
        cmp_wr_en = 2'b10; cmp_wr_data = 16'd3; step();
        act_sel = 4'b1001;                  // A toggle, B drive low
        tick_n(3);
        expect_out("R11 R5 B match at 3 drives low", 16'h0004, 2'b01, 2'b10);
        tick_n(2);
        expect_out("R4 R5 A match at 5 toggles", 16'h0006, 2'b00, 2'b11);

        flag_clr = 2'b11; step();
        expect_out("R4 clear both", 16'h0006, 2'b00, 2'b00);
        cnt_wr_en = 1; cnt_wr_data = 16'd5; step();
        expect_out("R3 counter load", 16'h0005, 2'b00, 2'b00);
        tick = 1; step();
        expect_out("R9 tick after load blocked", 16'h0006, 2'b00, 2'b00);

        cnt_wr_en = 1; cnt_wr_data = 16'd5; step();
        step();
        expect_out("R9 idle cycle keeps block pending", 16'h0005, 2'b00, 2'b00);
        tick = 1; step();
        expect_out("R9 late tick still blocked", 16'h0006, 2'b00, 2'b00);

        cnt_wr_en = 1; cnt_wr_data = 16'd4; step();
        tick = 1; step();
        tick = 1; flag_clr = 2'b01; step();
        expect_out("R9 R4 second tick compares, set beats clear", 16'h0006, 2'b01, 2'b01);

        cnt_wr_en = 1; tick = 1; cnt_wr_data = 16'h0100; step();
        expect_out("R3 write beats tick", 16'h0100, 2'b01, 2'b01);

        cnt_wr_en = 1; cnt_wr_data = 16'hFFFF; step();
        tick = 1; step();
        expect_out("R2 wrap to zero", 16'h0000, 2'b01, 2'b01);
        step();
        expect_out("R2 hold without tick", 16'h0000, 2'b01, 2'b01);

        flag_clr = 2'b11; step();
        force_stb = 2'b01; step();
        expect_out("R7 R8 force A toggles, no flag", 16'h0000, 2'b00, 2'b00);
        act_sel = 4'b1101;
        force_stb = 2'b10; step();
        expect_out("R7 force B drives high", 16'h0000, 2'b10, 2'b00);
        act_sel = 4'b1100;
        force_stb = 2'b01; step();
        expect_out("R5 hold code leaves output", 16'h0000, 2'b10, 2'b00);
        act_sel = 4'b1111;
        force_stb = 2'b01; step();
        expect_out("R5 force drive high", 16'h0000, 2'b11, 2'b00);
        act_sel = 4'b1110;
        force_stb = 2'b01; step();
        expect_out("R5 force drive low", 16'h0000, 2'b10, 2'b00);

        act_sel = 4'b0001;                  // A toggle, B hold
        force_stb = 2'b11; #0.5;
        vectors++;
        if (ctrl_rd !== 6'b000001) begin
            misses++;
            $display("FAIL R10 force bits: actual=%b expected=%b", ctrl_rd, 6'b000001);
        end
        step();
        expect_out("R10 R7 force A with hold on B", 16'h0000, 2'b11, 2'b00);

        ctc_mode = 1;
        cnt_wr_en = 1; cnt_wr_data = 16'd3; step();
        tick_n(2);
        expect_out("R9 blocked tick skips B at 3", 16'h0005, 2'b11, 2'b00);
        tick_n(1);
        expect_out("R6 A match clears counter", 16'h0000, 2'b10, 2'b01);
        tick_n(4);
        expect_out("R6 B match does not clear", 16'h0004, 2'b10, 2'b11);

        flag_clr = 2'b11; step();
        tick_n(1);
        expect_out("R6 counter steps to top value", 16'h0005, 2'b10, 2'b00);
        force_stb = 2'b01; step();
        expect_out("R8 force at top keeps counter and flags", 16'h0005, 2'b11, 2'b00);
        tick = 1; force_stb = 2'b01; step();
        expect_out("R7 force with match acts once", 16'h0000, 2'b10, 2'b01);

        step(); step();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            misses++;
            $display("FAIL R1 watchdog: actual=timeout expected=completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
            $finish;
        end
    end
endmodule